// File: doc/BRIEF.md
# IDE PIO Cycle Timing Generator

This block times programmed-I/O register accesses on one IDE channel that carries two drives. A request picks a drive and a direction. The block then drives a setup interval with no strobe, asserts the read or write strobe for an active interval, and samples the drive's ready line at the end of that interval. It follows with a recovery interval and finishes with a one-clock completion pulse. Every interval is counted in bus clocks.

Settings come from two inputs. The first is a 16-bit channel timing word. The second is a 4-bit word that holds alternative codes for drive 1. Codes are stored in complemented form: the active-interval code `s` means 5 − s clocks, and the recovery code `r` means 4 − r clocks. A drive that does not use fast timing for programmed I/O falls back to fixed, slower compatible counts. All settings are captured when a request is accepted. Changing them while an access is in flight does not affect that access.

Top module: `pio_strobe_timer`

## Requirements
- R1: After reset, `busy`, `rd_stb`, `wr_stb` and `done` are all low.
- R2: With fast timing in use, the strobe stays high for 5 − s clocks, where s is `chan_timing[9:8]` (or `slave_timing[3:2]` under R8).
- R3: With fast timing in use, exactly 4 − r clocks with `busy` high and no strobe follow the strobe, where r is `chan_timing[7:6]` (or `slave_timing[1:0]` under R8). `done` rises in the next clock.
- R4: When a drive's fast enable (`chan_timing[0]` for drive 0, `chan_timing[1]` for drive 1) is clear, the access uses compatible timing: setup COMPAT_SETUP, strobe COMPAT_ACT and recovery COMPAT_REC clocks (defaults 2, 6 and 5).
- R5: When a drive's ready-sample enable (`chan_timing[2]` for drive 0, `chan_timing[3]` for drive 1) is clear, `iordy` is ignored and the strobe ends on its count.
- R6: When the ready-sample enable is set and `iordy` is low at the last strobe clock, the strobe stays high until the first clock edge that samples `iordy` high. Recovery then starts.
- R7: When a drive's DMA-only bit (`chan_timing[4]` for drive 0, `chan_timing[5]` for drive 1) is set, its PIO accesses use compatible timing even if its fast enable is set.
- R8: When `chan_timing[10]` is set, drive 1 takes its active code from `slave_timing[3:2]` and its recovery code from `slave_timing[1:0]`. Drive 0 keeps the channel codes.
- R9: When the channel enable `chan_timing[11]` is clear, a request starts no access: `busy` stays low and no `done` appears.
- R10: `done` is high for exactly one clock after recovery, with `busy` low. A request made while `busy` is high is dropped.
- R11: An accepted request raises `busy` one edge later. `wr_req` = 1 gives `wr_stb` and `wr_req` = 0 gives `rd_stb`. Under fast timing FAST_SETUP clocks (default 1) come before the strobe.
- R12: Changing `chan_timing` after a request is accepted does not change that access's timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| chan_timing | input | 16 | Channel timing word (fields in R2 to R9) |
| slave_timing | input | 4 | Alternative drive-1 codes |
| req | input | 1 | Access request, taken when `busy` is low |
| drive_sel | input | 1 | Drive addressed by the request |
| wr_req | input | 1 | 1 = write, 0 = read |
| iordy | input | 1 | Drive ready line |
| rd_stb | output | 1 | Read strobe, active high |
| wr_stb | output | 1 | Write strobe, active high |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-clock completion pulse |

## Verification
Fast accesses are run with several pairs of active and recovery codes, in both directions. Each setup, strobe and recovery length is measured against the expected count, which tells the complemented decoding apart from a plain one. The same drive is then run with fast timing disabled and with the DMA-only bit set, so the compatible counts show which selection path was taken. Drive 1 is run with the alternative word on and off, and drive 0 with it on, to show that only drive 1 switches. Separate runs cover ready sampling with the line held low, sampling disabled with the line held low, a disabled channel, a request while busy, and a rewrite of the timing word in mid-access.

// File: rtl/pio_timing_pkg.sv
package pio_timing_pkg;

  localparam int NUM_DRIVES = 2;

  // channel timing word field positions
  localparam int TF_FAST    = 0;   // [1:0]  fast enable per drive
  localparam int TF_RDY     = 2;   // [3:2]  ready-sample enable per drive
  localparam int TF_DMAONLY = 4;   // [5:4]  fast timing for DMA only
  localparam int TF_REC     = 6;   // [7:6]  recovery code
  localparam int TF_SMP     = 8;   // [9:8]  active/sample code
  localparam int TF_ALT     = 10;  // alternative drive-1 word select
  localparam int TF_ON      = 11;  // channel enable

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_STROBE, ST_RECOV} pio_state_e;

  // complemented codes to clock counts
  function automatic logic [2:0] sample_clks(input logic [1:0] code);
    return 3'd5 - {1'b0, code};
  endfunction

  function automatic logic [2:0] recov_clks(input logic [1:0] code);
    return 3'd4 - {1'b0, code};
  endfunction

endpackage

// File: rtl/pio_timing_select.sv
module pio_timing_select
  import pio_timing_pkg::*;
#(
  parameter int CW           = 3,
  parameter int FAST_SETUP   = 1,
  parameter int COMPAT_SETUP = 2,
  parameter int COMPAT_ACT   = 6,
  parameter int COMPAT_REC   = 5
) (
  input  logic [15:0]   chan_timing,
  input  logic [3:0]    slave_timing,
  input  logic          drive_sel,
  output logic [CW-1:0] setup_clks,
  output logic [CW-1:0] act_clks,
  output logic [CW-1:0] rec_clks,
  output logic          rdy_chk,
  output logic          chan_on
);

  logic [NUM_DRIVES-1:0] fast_v, rdy_v, dma_v;

  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drive
    assign fast_v[d] = chan_timing[TF_FAST + d];
    assign rdy_v[d]  = chan_timing[TF_RDY + d];
    assign dma_v[d]  = chan_timing[TF_DMAONLY + d];
  end

  logic       use_alt, use_fast;
  logic [1:0] smp_code, rec_code;
  logic       unused_rsvd;

  assign unused_rsvd = ^chan_timing[15:12];
  assign use_alt  = drive_sel & chan_timing[TF_ALT];
  assign use_fast = fast_v[drive_sel] & ~dma_v[drive_sel];
  assign smp_code = use_alt ? slave_timing[3:2] : chan_timing[TF_SMP +: 2];
  assign rec_code = use_alt ? slave_timing[1:0] : chan_timing[TF_REC +: 2];
  assign rdy_chk  = rdy_v[drive_sel];
  assign chan_on  = chan_timing[TF_ON];

  always_comb begin
    if (use_fast) begin
      setup_clks = CW'(FAST_SETUP);
      act_clks   = CW'(sample_clks(smp_code));
      rec_clks   = CW'(recov_clks(rec_code));
    end else begin
      setup_clks = CW'(COMPAT_SETUP);
      act_clks   = CW'(COMPAT_ACT);
      rec_clks   = CW'(COMPAT_REC);
    end
  end

endmodule

// File: rtl/pio_cycle_fsm.sv
module pio_cycle_fsm
  import pio_timing_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          chan_on,
  input  logic          wr_in,
  input  logic          iordy,
  input  logic [CW-1:0] setup_clks,
  input  logic [CW-1:0] act_clks,
  input  logic [CW-1:0] rec_clks,
  input  logic          rdy_chk,
  output logic          rd_stb,
  output logic          wr_stb,
  output logic          busy,
  output logic          done
);

  pio_state_e    state;
  logic [CW-1:0] cnt, act_q, rec_q;
  logic          rdy_q, wr_q, done_q;

  // named events
  logic accept, cnt_zero, rdy_stall, strobe_end, recov_end;
  assign accept     = (state == ST_IDLE) && req && chan_on;
  assign cnt_zero   = (cnt == '0);
  assign rdy_stall  = (state == ST_STROBE) && cnt_zero && rdy_q && !iordy;
  assign strobe_end = (state == ST_STROBE) && cnt_zero && !rdy_stall;
  assign recov_end  = (state == ST_RECOV) && cnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      act_q  <= '0;
      rec_q  <= '0;
      rdy_q  <= 1'b0;
      wr_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= recov_end;
      case (state)
        ST_IDLE: if (accept) begin
          state <= ST_SETUP;
          cnt   <= setup_clks - CW'(1);
          act_q <= act_clks;
          rec_q <= rec_clks;
          rdy_q <= rdy_chk;
          wr_q  <= wr_in;
        end
        ST_SETUP: if (cnt_zero) begin
          state <= ST_STROBE;
          cnt   <= act_q - CW'(1);
        end else cnt <= cnt - CW'(1);
        ST_STROBE: if (strobe_end) begin
          state <= ST_RECOV;
          cnt   <= rec_q - CW'(1);
        end else if (!cnt_zero) cnt <= cnt - CW'(1);
        ST_RECOV: if (recov_end) state <= ST_IDLE;
                  else cnt <= cnt - CW'(1);
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy   = (state != ST_IDLE);
  assign rd_stb = (state == ST_STROBE) && !wr_q;
  assign wr_stb = (state == ST_STROBE) && wr_q;
  assign done   = done_q;

  assert_rdy_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_stall |=> (state == ST_STROBE));

  assert_no_rdy_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_STROBE) && cnt_zero && !rdy_q) |=> (state == ST_RECOV));

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_follows_recovery_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(state == ST_RECOV) && !busy));

  assert_start_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req && chan_on));

  assert_setup_first_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_stb || wr_stb) |-> $past(busy));

  assert_settings_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(act_q) && $stable(rec_q)));

endmodule

// File: rtl/pio_strobe_timer.sv
module pio_strobe_timer #(
  parameter int FAST_SETUP   = 1,
  parameter int COMPAT_SETUP = 2,
  parameter int COMPAT_ACT   = 6,
  parameter int COMPAT_REC   = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] chan_timing,
  input  logic [3:0]  slave_timing,
  input  logic        req,
  input  logic        drive_sel,
  input  logic        wr_req,
  input  logic        iordy,
  output logic        rd_stb,
  output logic        wr_stb,
  output logic        busy,
  output logic        done
);

  localparam int MAX_A  = (COMPAT_ACT > 5) ? COMPAT_ACT : 5;
  localparam int MAX_B  = (COMPAT_REC > COMPAT_SETUP) ? COMPAT_REC : COMPAT_SETUP;
  localparam int MAX_C  = (MAX_B > FAST_SETUP) ? MAX_B : FAST_SETUP;
  localparam int MAX_ALL = (MAX_A > MAX_C) ? MAX_A : MAX_C;
  localparam int CW     = $clog2(MAX_ALL + 1);

  logic [CW-1:0] setup_clks, act_clks, rec_clks;
  logic          rdy_chk, chan_on;

  pio_timing_select #(
    .CW(CW), .FAST_SETUP(FAST_SETUP), .COMPAT_SETUP(COMPAT_SETUP),
    .COMPAT_ACT(COMPAT_ACT), .COMPAT_REC(COMPAT_REC)
  ) u_sel (
    .chan_timing (chan_timing),
    .slave_timing(slave_timing),
    .drive_sel   (drive_sel),
    .setup_clks  (setup_clks),
    .act_clks    (act_clks),
    .rec_clks    (rec_clks),
    .rdy_chk     (rdy_chk),
    .chan_on     (chan_on)
  );

  pio_cycle_fsm #(.CW(CW)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req),
    .chan_on   (chan_on),
    .wr_in     (wr_req),
    .iordy     (iordy),
    .setup_clks(setup_clks),
    .act_clks  (act_clks),
    .rec_clks  (rec_clks),
    .rdy_chk   (rdy_chk),
    .rd_stb    (rd_stb),
    .wr_stb    (wr_stb),
    .busy      (busy),
    .done      (done)
  );

endmodule

// File: tb/pio_strobe_timer_test.sv
`timescale 1ns/1ps
module pio_strobe_timer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] chan_timing = '0;
  logic [3:0]  slave_timing = '0;
  logic        req = 1'b0, drive_sel = 1'b0, wr_req = 1'b0, iordy = 1'b1;
  logic        rd_stb, wr_stb, busy, done;

  always #2.5 clk = ~clk;

  pio_strobe_timer uut (
    .clk(clk), .rst_n(rst_n), .chan_timing(chan_timing), .slave_timing(slave_timing),
    .req(req), .drive_sel(drive_sel), .wr_req(wr_req), .iordy(iordy),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .busy(busy), .done(done)
  );

  int n_chk = 0, n_bad = 0, pushed = 0, completed = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected lengths, written from the requirement text
  function automatic int x_su(input bit fast);  return fast ? 1 : 2; endfunction
  function automatic int x_act(input bit fast, input int s); return fast ? 2 + (3 - s) : 6; endfunction
  function automatic int x_rec(input bit fast, input int r); return fast ? 1 + (3 - r) : 5; endfunction

  function automatic logic [15:0] word(input bit f0, f1, y0, y1, m0, m1,
                                       input int rec, smp, input bit alt, on);
    logic [15:0] w = '0;
    w[0] = f0; w[1] = f1; w[2] = y0; w[3] = y1; w[4] = m0; w[5] = m1;
    w[7:6] = rec[1:0]; w[9:8] = smp[1:0]; w[10] = alt; w[11] = on;
    return w;
  endfunction

  typedef struct { bit wr; int su; int act; int rec; string tag; } exp_t;
  exp_t exp_q[$];

  // monitor
  int  m_su, m_act, m_rec;
  bit  m_in = 0, m_seen = 0, m_wr = 0;
  always @(negedge clk) if (rst_n) begin
    if (busy) begin
      if (!m_in) begin m_in = 1; m_seen = 0; m_su = 0; m_act = 0; m_rec = 0; end
      if (rd_stb || wr_stb) begin m_seen = 1; m_act++; m_wr = wr_stb; end
      else if (!m_seen) m_su++;
      else m_rec++;
    end
    if (done) begin
      exp_t e;
      completed++;
      check(!busy, "R10 busy low with done", busy, 0);
      if (exp_q.size() == 0) check(0, "R10 unexpected completion", completed, pushed);
      else begin
        e = exp_q.pop_front();
        check(m_su == e.su, {e.tag, " setup"}, m_su, e.su);
        check(m_act == e.act, {e.tag, " strobe"}, m_act, e.act);
        check(m_rec == e.rec, {e.tag, " recovery"}, m_rec, e.rec);
        check(m_wr == e.wr, {e.tag, " direction R11"}, m_wr, e.wr);
      end
      m_in = 0;
    end
  end

  // driver
  task automatic run_cycle(input bit drv, input bit wr, input int hold,
                           input int esu, input int eact, input int erec, input string tag,
                           input bit poke, input bit swap, input logic [15:0] swap_w);
    int seen = 0;
    @(negedge clk);
    while (busy) @(negedge clk);
    iordy = (hold > 0) ? 1'b0 : 1'b1;
    drive_sel = drv; wr_req = wr; req = 1'b1;
    exp_q.push_back('{wr, esu, eact, erec, tag});
    pushed++;
    @(negedge clk);
    req = 1'b0;
    if (swap) chan_timing = swap_w;
    while (1) begin
      if (rd_stb || wr_stb) begin
        seen++;
        if (poke && seen == 1) req = 1'b1;
        if (poke && seen == 2) req = 1'b0;
        if (hold > 0 && seen == hold) iordy = 1'b1;
      end
      if (done) break;
      @(negedge clk);
    end
    iordy = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", completed, pushed);
    $display("test done: total=%0d bad=%0d", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check({busy, rd_stb, wr_stb, done} == 4'b0, "R1 reset outputs", {busy, rd_stb, wr_stb, done}, 0);
    rst_n = 1'b1;

    // R2 R3 R11: fast timing codes, both directions
    chan_timing = word(1,1,0,0,0,0, 0,0, 0,1);
    run_cycle(0, 0, 0, x_su(1), x_act(1,0), x_rec(1,0), "R2 R3 s0 r0 read", 0, 0, '0);
    chan_timing = word(1,1,0,0,0,0, 3,3, 0,1);
    run_cycle(0, 1, 0, x_su(1), x_act(1,3), x_rec(1,3), "R2 R3 s3 r3 write", 0, 0, '0);
    chan_timing = word(1,1,0,0,0,0, 1,2, 0,1);
    run_cycle(1, 0, 0, x_su(1), x_act(1,2), x_rec(1,1), "R2 R3 s2 r1 drive1", 0, 0, '0);

    // R4: fast enable clear
    chan_timing = word(0,1,0,0,0,0, 3,3, 0,1);
    run_cycle(0, 0, 0, x_su(0), x_act(0,3), x_rec(0,3), "R4 compatible", 0, 0, '0);
    // R7: DMA-only bit forces compatible PIO
    chan_timing = word(1,1,0,0,1,0, 3,3, 0,1);
    run_cycle(0, 1, 0, x_su(0), x_act(0,3), x_rec(0,3), "R7 dma only", 0, 0, '0);

    // R8: alternative drive-1 codes
    slave_timing = 4'b11_10;   // sample code 3, recovery code 2
    chan_timing = word(1,1,0,0,0,0, 0,0, 1,1);
    run_cycle(1, 0, 0, x_su(1), x_act(1,3), x_rec(1,2), "R8 drive1 alt word", 0, 0, '0);
    run_cycle(0, 0, 0, x_su(1), x_act(1,0), x_rec(1,0), "R8 drive0 keeps channel", 0, 0, '0);
    chan_timing = word(1,1,0,0,0,0, 0,0, 0,1);
    run_cycle(1, 0, 0, x_su(1), x_act(1,0), x_rec(1,0), "R8 alt off", 0, 0, '0);

    // R6 / R5: ready sampling
    chan_timing = word(1,1,1,0,0,0, 2,2, 0,1);
    run_cycle(0, 0, 0, x_su(1), x_act(1,2), x_rec(1,2), "R6 ready high", 0, 0, '0);
    run_cycle(0, 0, x_act(1,2) + 3, x_su(1), x_act(1,2) + 3, x_rec(1,2), "R6 ready stall", 0, 0, '0);
    run_cycle(1, 1, x_act(1,2) + 3, x_su(1), x_act(1,2), x_rec(1,2), "R5 ready ignored", 0, 0, '0);

    // R10: request while busy is dropped
    chan_timing = word(0,0,0,0,0,0, 0,0, 0,1);
    run_cycle(0, 0, 0, x_su(0), 6, 5, "R10 poke while busy", 1, 0, '0);

    // R12: rewrite timing word mid access
    chan_timing = word(1,1,0,0,0,0, 0,0, 0,1);
    run_cycle(0, 1, 0, x_su(1), x_act(1,0), x_rec(1,0), "R12 settings captured", 0, 1,
              word(1,1,0,0,0,0, 3,3, 0,1));

    // R9: channel disabled
    chan_timing = word(1,1,0,0,0,0, 0,0, 0,0);
    @(negedge clk); req = 1'b1;
    @(negedge clk); req = 1'b0;
    begin
      int hits = 0;
      for (int i = 0; i < 12; i++) begin
        if (busy || done || rd_stb || wr_stb) hits++;
        @(negedge clk);
      end
      check(hits == 0, "R9 disabled channel idle", hits, 0);
    end

    repeat (4) @(negedge clk);
    check(completed == pushed, "R10 completions match requests", completed, pushed);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule